// File: doc/BRIEF.md
# DMA Control Register Slave with Event Interrupts

This block is the software-facing register slave of a four-channel DMA engine. An AXI4-Lite master writes and reads a small register space. The space holds two global control bits, a mask that enables channels, and one 32-bit descriptor pointer per channel. All of these are driven straight out to the transfer datapath. A read of the status word returns a live snapshot of the engine's busy input together with the accumulated per-channel completion and error flags.

The datapath reports one event code per channel each cycle. A completion or fault code sets a sticky flag for that channel. Software clears a flag by writing a one to its status bit. Each flag drives a level interrupt for its channel only while both the global enable and the interrupt enable are set.

The AXI4-Lite channels follow valid/ready rules. A write is taken only in a cycle where address and data are both valid and no write response is still waiting. The response stays valid until the master takes it, and no new write is taken during that time. A read is taken only while no read data is waiting. The read data and response are held unchanged until the master raises ready.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero, all flags and interrupt outputs are low, and neither response channel is valid.
- R2: A write is accepted, with awready and wready high together, only in a cycle where awvalid and wvalid are both high and bvalid is low. bvalid rises on the next cycle and stays high with bresp 00 until bready is sampled high. The written value appears on the outputs in the cycle after acceptance.
- R3: arready is high exactly when rvalid is low. rvalid rises in the cycle after a read is accepted. While rready is low, rvalid stays high and rdata stays unchanged. rresp is always 00.
- R4: Offset 0x000 is control, with bit 0 as the global enable and bit 1 as the interrupt enable; its other bits read as zero. Offset 0x008 holds the channel-enable mask in bits [3:0]; its other bits read as zero.
- R5: Channel n's descriptor pointer is a full 32-bit register at offset 0x100 + 4·n, for n = 0 to 3.
- R6: Each write strobe bit k gates data byte k (bits 8k+7..8k). A byte whose strobe is low keeps its old value.
- R7: ev_code[2n+1:2n] is the event code of channel n. Code 01 sets the channel's sticky done flag and code 10 sets its sticky error flag. Codes 00 and 11 change nothing. A flag stays set until it is cleared.
- R8: The status word at offset 0x004 has bit 0 equal to busy_i, bit 1 equal to the OR of all error flags, the done flags in bits [11:8], the error flags in bits [15:12], and zeros elsewhere.
- R9: A status write clears each flag whose status bit is written as 1, but only where the strobe of byte 1 is high. An event that arrives in the same cycle as its clear leaves the flag set.
- R10: irq_done_o[n] and irq_error_o[n] equal the done and error flags of channel n when the global enable and the interrupt enable are both 1. Otherwise they are 0.
- R11: A read at an unmapped or misaligned offset returns zero with response 00. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_awaddr | input | 12 | Write address (byte offset) |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address ready |
| cfg_wdata | input | 32 | Write data |
| cfg_wstrb | input | 4 | Write byte strobes |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data ready |
| cfg_bresp | output | 2 | Write response, always 00 |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response ready |
| cfg_araddr | input | 12 | Read address (byte offset) |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address ready |
| cfg_rdata | output | 32 | Read data |
| cfg_rresp | output | 2 | Read response, always 00 |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data ready |
| ev_code | input | 8 | Two-bit event code per channel |
| busy_i | input | 1 | Live busy indication from the datapath |
| glb_en_o | output | 1 | Global enable bit |
| irq_en_o | output | 1 | Interrupt enable bit |
| ch_en_o | output | 4 | Channel-enable mask |
| desc_ptr_o | output | 128 | Descriptor pointers, channel n in bits [32n+31:32n] |
| irq_done_o | output | 4 | Gated per-channel done interrupts |
| irq_error_o | output | 4 | Gated per-channel error interrupts |

## Verification
The hardest case to reach is an event that lands on the same clock edge at which software clears that flag. The bench raises a done code together with the write valids on the same falling edge. Since no response is pending, the write is accepted at the very next rising edge. The code is then dropped on the following falling edge, so event and clear meet at exactly one edge. The other hard case is back-pressure: the bench withholds bready and rready for several cycles and offers a second write meanwhile, to show that nothing moves while a response waits.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_DONE = 2'b01,
    EV_ERR  = 2'b10
  } ev_code_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // word indices (byte offset / 4)
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_CHEN = 2;
  localparam int IDX_DESC = 64;

  // status word layout
  localparam int ST_BUSY  = 0;
  localparam int ST_ERR   = 1;
  localparam int DONE_LSB = 8;

  function automatic logic [DW-1:0] strb_mask(input logic [SW-1:0] strb);
    logic [DW-1:0] m;
    for (int b = 0; b < SW; b++) m[8*b +: 8] = {8{strb[b]}};
    return m;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                          input logic [DW-1:0] new_v,
                                          input logic [SW-1:0] strb);
    logic [DW-1:0] m;
    m = strb_mask(strb);
    return (new_v & m) | (old_v & ~m);
  endfunction
endpackage

// File: rtl/dcr_wr_port.sv
module dcr_wr_port
  import dcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic awvalid,
  output logic awready,
  input  logic wvalid,
  output logic wready,
  output logic [1:0] bresp,
  output logic bvalid,
  input  logic bready,
  output logic we_o
);
  logic bvalid_q;
  logic take;

  assign take    = awvalid && wvalid && !bvalid_q;
  assign awready = take;
  assign wready  = take;
  assign we_o    = take;
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bvalid_q <= 1'b0;
    else if (take)   bvalid_q <= 1'b1;
    else if (bready) bvalid_q <= 1'b0;
  end
endmodule

// File: rtl/dcr_rd_port.sv
module dcr_rd_port
  import dcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arvalid,
  output logic arready,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] rdata,
  output logic [1:0] rresp,
  output logic rvalid,
  input  logic rready
);
  logic rvalid_q;
  logic [DW-1:0] rdata_q;

  assign arready = !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && !rvalid_q) begin
      rvalid_q <= 1'b1;
      rdata_q  <= word_i;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dcr_reg_file.sv
module dcr_reg_file
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_CH   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] wstrb,
  input  logic [ADDR_W-1:0] raddr,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] rword_o,
  output logic stat_we_o,
  output logic glb_en_o,
  output logic irq_en_o,
  output logic [N_CH-1:0] ch_en_o,
  output logic [N_CH*DW-1:0] desc_o
);
  localparam int IW = ADDR_W - 2;

  logic [1:0]      ctrl_q;
  logic [N_CH-1:0] chen_q;
  logic [DW-1:0]   desc_q [N_CH];
  logic [DW-1:0]   ctrl_nx, chen_nx;
  logic [IW-1:0]   widx, ridx;
  logic            wal, ral;

  assign widx = waddr[ADDR_W-1:2];
  assign ridx = raddr[ADDR_W-1:2];
  assign wal  = (waddr[1:0] == 2'b00);
  assign ral  = (raddr[1:0] == 2'b00);

  assign ctrl_nx   = merge(DW'(ctrl_q), wdata, wstrb);
  assign chen_nx   = merge(DW'(chen_q), wdata, wstrb);
  assign stat_we_o = we && wal && (widx == IW'(IDX_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      chen_q <= '0;
    end else if (we && wal) begin
      if (widx == IW'(IDX_CTRL)) ctrl_q <= ctrl_nx[1:0];
      if (widx == IW'(IDX_CHEN)) chen_q <= chen_nx[N_CH-1:0];
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_desc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) desc_q[g] <= '0;
      else if (we && wal && widx == IW'(IDX_DESC + g))
        desc_q[g] <= merge(desc_q[g], wdata, wstrb);
    end
    assign desc_o[g*DW +: DW] = desc_q[g];
  end

  always_comb begin
    rword_o = '0;
    if (ral) begin
      if (ridx == IW'(IDX_CTRL)) rword_o = DW'(ctrl_q);
      if (ridx == IW'(IDX_STAT)) rword_o = status_i;
      if (ridx == IW'(IDX_CHEN)) rword_o = DW'(chen_q);
      for (int c = 0; c < N_CH; c++)
        if (ridx == IW'(IDX_DESC + c)) rword_o = desc_q[c];
    end
  end

  assign glb_en_o = ctrl_q[0];
  assign irq_en_o = ctrl_q[1];
  assign ch_en_o  = chen_q;
endmodule

// File: rtl/dcr_irq_flags.sv
module dcr_irq_flags
  import dcr_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [2*N_CH-1:0] ev_code,
  input  logic clr_en,
  input  logic [N_CH-1:0] clr_done,
  input  logic [N_CH-1:0] clr_err,
  input  logic gate,
  output logic [N_CH-1:0] done_q,
  output logic [N_CH-1:0] err_q,
  output logic [N_CH-1:0] irq_done,
  output logic [N_CH-1:0] irq_err
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic set_d, set_e;
    assign set_d = (ev_code[2*g +: 2] == EV_DONE);
    assign set_e = (ev_code[2*g +: 2] == EV_ERR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q[g] <= 1'b0;
        err_q[g]  <= 1'b0;
      end else begin
        if (set_d)                    done_q[g] <= 1'b1;
        else if (clr_en && clr_done[g]) done_q[g] <= 1'b0;
        if (set_e)                    err_q[g]  <= 1'b1;
        else if (clr_en && clr_err[g])  err_q[g]  <= 1'b0;
      end
    end
  end

  assign irq_done = done_q & {N_CH{gate}};
  assign irq_err  = err_q  & {N_CH{gate}};
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_CH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_awaddr,
  input  logic              cfg_awvalid,
  output logic              cfg_awready,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [SW-1:0]     cfg_wstrb,
  input  logic              cfg_wvalid,
  output logic              cfg_wready,
  output logic [1:0]        cfg_bresp,
  output logic              cfg_bvalid,
  input  logic              cfg_bready,
  input  logic [ADDR_W-1:0] cfg_araddr,
  input  logic              cfg_arvalid,
  output logic              cfg_arready,
  output logic [DW-1:0]     cfg_rdata,
  output logic [1:0]        cfg_rresp,
  output logic              cfg_rvalid,
  input  logic              cfg_rready,
  input  logic [2*N_CH-1:0] ev_code,
  input  logic              busy_i,
  output logic              glb_en_o,
  output logic              irq_en_o,
  output logic [N_CH-1:0]   ch_en_o,
  output logic [N_CH*DW-1:0] desc_ptr_o,
  output logic [N_CH-1:0]   irq_done_o,
  output logic [N_CH-1:0]   irq_error_o
);
  localparam int ERR_LSB = DONE_LSB + N_CH;

  logic            we, stat_we;
  logic [DW-1:0]   rword, status, clr_bits;
  logic [N_CH-1:0] done_f, err_f;

  dcr_wr_port u_wr (
    .clk, .rst_n,
    .awvalid(cfg_awvalid), .awready(cfg_awready),
    .wvalid(cfg_wvalid), .wready(cfg_wready),
    .bresp(cfg_bresp), .bvalid(cfg_bvalid), .bready(cfg_bready),
    .we_o(we)
  );

  dcr_rd_port u_rd (
    .clk, .rst_n,
    .arvalid(cfg_arvalid), .arready(cfg_arready), .word_i(rword),
    .rdata(cfg_rdata), .rresp(cfg_rresp), .rvalid(cfg_rvalid), .rready(cfg_rready)
  );

  dcr_reg_file #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_regs (
    .clk, .rst_n, .we, .waddr(cfg_awaddr), .wdata(cfg_wdata), .wstrb(cfg_wstrb),
    .raddr(cfg_araddr), .status_i(status), .rword_o(rword), .stat_we_o(stat_we),
    .glb_en_o, .irq_en_o, .ch_en_o, .desc_o(desc_ptr_o)
  );

  always_comb begin
    status = '0;
    status[ST_BUSY] = busy_i;
    status[ST_ERR]  = |err_f;
    status[DONE_LSB +: N_CH] = done_f;
    status[ERR_LSB  +: N_CH] = err_f;
  end

  assign clr_bits = cfg_wdata & strb_mask(cfg_wstrb);

  dcr_irq_flags #(.N_CH(N_CH)) u_flags (
    .clk, .rst_n, .ev_code, .clr_en(stat_we),
    .clr_done(clr_bits[DONE_LSB +: N_CH]), .clr_err(clr_bits[ERR_LSB +: N_CH]),
    .gate(glb_en_o && irq_en_o),
    .done_q(done_f), .err_q(err_f),
    .irq_done(irq_done_o), .irq_err(irq_error_o)
  );
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int ADDR_W = 12,
  parameter int N_CH   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_awvalid,
  input logic cfg_awready,
  input logic cfg_wvalid,
  input logic cfg_wready,
  input logic [1:0] cfg_bresp,
  input logic cfg_bvalid,
  input logic cfg_bready,
  input logic cfg_arready,
  input logic [31:0] cfg_rdata,
  input logic [1:0] cfg_rresp,
  input logic cfg_rvalid,
  input logic cfg_rready,
  input logic glb_en_o,
  input logic irq_en_o,
  input logic [N_CH-1:0] irq_done_o,
  input logic [N_CH-1:0] irq_error_o
);
  p_accept_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_awready |-> (cfg_awvalid && cfg_wvalid && cfg_wready && !cfg_bvalid));
  p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bvalid && !cfg_bready) |=> cfg_bvalid);
  p_bresp_okay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bvalid |-> (cfg_bresp == 2'b00));
  p_ar_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_arready |-> !cfg_rvalid);
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && !cfg_rready) |=> (cfg_rvalid && $stable(cfg_rdata)));
  p_rresp_okay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> (cfg_rresp == 2'b00));
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_done_o != '0) || (irq_error_o != '0)) |-> (glb_en_o && irq_en_o));
endmodule

bind dma_ctrl_regs dcr_checker #(.ADDR_W(ADDR_W), .N_CH(N_CH)) chk_i (.*);

// File: tb/dma_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module dma_ctrl_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] cfg_awaddr = '0, cfg_araddr = '0;
  logic cfg_awvalid = 0, cfg_wvalid = 0, cfg_bready = 0, cfg_arvalid = 0, cfg_rready = 0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0] cfg_wstrb = '0;
  logic [7:0] ev_code = '0;
  logic busy_i = 0;
  logic cfg_awready, cfg_wready, cfg_bvalid, cfg_arready, cfg_rvalid;
  logic [1:0] cfg_bresp, cfg_rresp;
  logic [31:0] cfg_rdata;
  logic glb_en_o, irq_en_o;
  logic [3:0] ch_en_o, irq_done_o, irq_error_o;
  logic [127:0] desc_ptr_o;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_ctrl_regs dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic axi_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    cfg_awaddr = a; cfg_wdata = d; cfg_wstrb = s;
    cfg_awvalid = 1; cfg_wvalid = 1;
    @(posedge clk); @(negedge clk);
    cfg_awvalid = 0; cfg_wvalid = 0; ev_code = '0;
    cfg_bready = 1;
    @(posedge clk); @(negedge clk);
    cfg_bready = 0;
  endtask

  task automatic axi_read(input logic [11:0] a, output logic [31:0] d, output logic [1:0] r);
    cfg_araddr = a; cfg_arvalid = 1;
    @(posedge clk); @(negedge clk);
    cfg_arvalid = 0;
    d = cfg_rdata; r = cfg_rresp;
    cfg_rready = 1;
    @(posedge clk); @(negedge clk);
    cfg_rready = 0;
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic [1:0] r;
    axi_read(a, d, r);
    chk(req, d, exp);
    chk(req, 32'(r), 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 bvalid", 32'(cfg_bvalid), 0);
    chk("R1 rvalid", 32'(cfg_rvalid), 0);
    chk("R1 irq", {24'h0, irq_done_o, irq_error_o}, 0);
    read_chk("R1 ctrl", 12'h000, 0);
    read_chk("R1 status", 12'h004, 0);
    read_chk("R1 chen", 12'h008, 0);
    for (int n = 0; n < 4; n++) read_chk("R1 desc", 12'(12'h100 + 4*n), 0);
  endtask

  task automatic t_write_handshake();
    cfg_awaddr = 12'h000; cfg_wdata = 32'h1; cfg_wstrb = 4'hF; cfg_awvalid = 1;
    for (int i = 0; i < 2; i++) begin
      #1 chk("R2 aw alone not ready", 32'(cfg_awready), 0);
      @(posedge clk); @(negedge clk);
      chk("R2 no bvalid without wvalid", 32'(cfg_bvalid), 0);
    end
    cfg_wvalid = 1;
    #1 chk("R2 ready with both", {cfg_awready, cfg_wready}, 32'h3);
    @(posedge clk); @(negedge clk);
    chk("R2 bvalid next cycle", 32'(cfg_bvalid), 1);
    chk("R2 value visible", 32'(glb_en_o), 1);
    cfg_wdata = 32'h2;   // second write offered while response pending
    for (int i = 0; i < 3; i++) begin
      chk("R2 no accept while pending", 32'(cfg_awready), 0);
      @(posedge clk); @(negedge clk);
      chk("R2 bvalid held", 32'(cfg_bvalid), 1);
      chk("R2 bresp okay", 32'(cfg_bresp), 0);
    end
    cfg_awvalid = 0; cfg_wvalid = 0; cfg_bready = 1;
    @(posedge clk); @(negedge clk);
    cfg_bready = 0;
    chk("R2 bvalid drops", 32'(cfg_bvalid), 0);
    read_chk("R2 only first write", 12'h000, 32'h1);
  endtask

  task automatic t_read_hold();
    logic [31:0] d0;
    axi_write(12'h108, 32'hCAFE_0102, 4'hF);
    cfg_araddr = 12'h108; cfg_arvalid = 1;
    #1 chk("R3 arready idle", 32'(cfg_arready), 1);
    @(posedge clk); @(negedge clk);
    cfg_arvalid = 0; d0 = cfg_rdata;
    chk("R3 rvalid next", 32'(cfg_rvalid), 1);
    chk("R3 data", d0, 32'hCAFE_0102);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R3 rvalid held", 32'(cfg_rvalid), 1);
      chk("R3 rdata stable", cfg_rdata, d0);
      chk("R3 arready low", 32'(cfg_arready), 0);
    end
    cfg_rready = 1;
    @(posedge clk); @(negedge clk);
    cfg_rready = 0;
    chk("R3 rvalid drops", 32'(cfg_rvalid), 0);
  endtask

  task automatic t_map();
    axi_write(12'h000, 32'hFFFF_FFFF, 4'hF);
    chk("R4 enables out", {30'h0, irq_en_o, glb_en_o}, 32'h3);
    read_chk("R4 ctrl reads", 12'h000, 32'h3);
    axi_write(12'h008, 32'h0000_00FF, 4'hF);
    chk("R4 chen out", 32'(ch_en_o), 32'hF);
    read_chk("R4 chen reads", 12'h008, 32'hF);
    for (int n = 0; n < 4; n++)
      axi_write(12'(12'h100 + 4*n), 32'h1000_0000 + 32'(n) * 32'h0101_1111, 4'hF);
    for (int n = 0; n < 4; n++) begin
      read_chk("R5 desc read", 12'(12'h100 + 4*n), 32'h1000_0000 + 32'(n) * 32'h0101_1111);
      chk("R5 desc port", desc_ptr_o[32*n +: 32], 32'h1000_0000 + 32'(n) * 32'h0101_1111);
    end
  endtask

  task automatic t_strobe();
    axi_write(12'h100, 32'hAABB_CCDD, 4'hF);
    axi_write(12'h100, 32'h1122_3344, 4'b0101);
    read_chk("R6 byte merge", 12'h100, 32'hAA22_CC44);
    axi_write(12'h000, 32'h0000_0000, 4'b0000);
    read_chk("R6 no strobe no change", 12'h000, 32'h3);
  endtask

  task automatic t_unmapped();
    axi_write(12'h00C, 32'hFFFF_FFFF, 4'hF);
    axi_write(12'h101, 32'h0, 4'hF);
    read_chk("R11 unmapped 0x00C", 12'h00C, 0);
    read_chk("R11 unmapped 0x110", 12'h110, 0);
    read_chk("R11 misaligned", 12'h102, 0);
    read_chk("R11 desc0 untouched", 12'h100, 32'hAA22_CC44);
    read_chk("R11 ctrl untouched", 12'h000, 32'h3);
  endtask

  task automatic t_events();
    axi_write(12'h000, 32'h0, 4'hF);
    busy_i = 1;
    ev_code = {2'b11, 2'b10, 2'b01, 2'b00};  // ch3=11 ch2=err ch1=done ch0=none
    @(posedge clk); @(negedge clk);
    ev_code = '0;
    repeat (2) @(negedge clk);
    read_chk("R7 R8 status sticky", 12'h004, 32'h0000_4203);
    chk("R10 gated off", {24'h0, irq_done_o, irq_error_o}, 0);
    axi_write(12'h000, 32'h1, 4'hF);
    chk("R10 global only", {24'h0, irq_done_o, irq_error_o}, 0);
    axi_write(12'h000, 32'h2, 4'hF);
    chk("R10 irq-en only", {24'h0, irq_done_o, irq_error_o}, 0);
    axi_write(12'h000, 32'h3, 4'hF);
    chk("R10 both enabled", {24'h0, irq_done_o, irq_error_o}, {24'h0, 4'b0010, 4'b0100});
    busy_i = 0;
    read_chk("R8 busy live", 12'h004, 32'h0000_4202);
  endtask

  task automatic t_clear();
    axi_write(12'h004, 32'h0000_0200, 4'b0010);
    read_chk("R9 clear done1", 12'h004, 32'h0000_4002);
    chk("R9 irq done cleared", 32'(irq_done_o), 0);
    axi_write(12'h004, 32'h0000_4000, 4'b0001);
    read_chk("R9 byte1 strobe needed", 12'h004, 32'h0000_4002);
    axi_write(12'h004, 32'h0000_4000, 4'b0010);
    read_chk("R9 clear err2", 12'h004, 0);
    chk("R9 irq err cleared", 32'(irq_error_o), 0);
    ev_code = 8'b0000_0001;   // ch0 done on the same edge as its clear
    axi_write(12'h004, 32'h0000_0100, 4'b0010);
    read_chk("R9 set wins over clear", 12'h004, 32'h0000_0100);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_handshake();
    t_read_hold();
    t_map();
    t_strobe();
    t_unmapped();
    t_events();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule